// File: doc/BRIEF.md
# Signed Multiply-Accumulate Unit with Shifted Drain

This unit keeps a signed 64-bit running sum in two 32-bit halves and updates it once per clock. Each cycle the caller either leaves the sum alone, adds the full signed product of two 32-bit operands to it, subtracts that product from it, or drains it. A drain captures a 32-bit window of the sum and zeroes both halves in the same clock edge. The window is the sum shifted right arithmetically by 28 places and cut to its low 32 bits. Every operation finishes in one cycle, so a drain may follow an accumulate directly and sees its result, with no stall.

Both halves can also be loaded from a shared write-data bus, so a sum can be preset or restored. Each half has its own write enable. If an operation other than idle is issued in the same cycle, the operation wins and the write is dropped. Both halves are visible on outputs at all times.

The operation select is a 2-bit code: `00` idle, `01` multiply-add, `10` multiply-subtract, `11` drain. The datapath is a single cycle and has no sequencing state. Behaviour is chosen by a unique case over this code, which is the only enumerated type in the design.

Top module: `mac_acc_unit`

## Requirements
- R1: While reset (`rst_n` low) is asserted and in the first cycle after it, `acc_lo_o`, `acc_hi_o` and `drain_o` are all zero.
- R2: With `op_i` = `01`, after the next rising edge the 64-bit sum {`acc_hi_o`,`acc_lo_o`} equals its previous value plus the signed 64-bit product of `a_i` and `b_i`.
- R3: With `op_i` = `10`, after the next rising edge the sum equals its previous value minus the full signed 64-bit product of `a_i` and `b_i`.
- R4: With `op_i` = `11`, after the next rising edge `drain_o` holds bits 59:28 of the previous sum (the sum shifted right by 28 places), and both halves read zero.
- R5: Operations issued in consecutive cycles each act on the result of the one before, with no idle cycle between them.
- R6: With `op_i` = `00`, `lo_we_i` high loads `wdata_i` into `acc_lo_o` and `hi_we_i` high loads it into `acc_hi_o` after the next edge. A half whose enable is low keeps its value.
- R7: When `op_i` is not `00`, `lo_we_i` and `hi_we_i` have no effect, and the result is that of the operation alone.
- R8: With `op_i` = `00` and both write enables low, both halves keep their value. `drain_o` changes only on a drain.
- R9: The sum wraps modulo 2^64 on overflow or underflow, with no saturation.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_i | input | 2 | Operation: 00 idle, 01 multiply-add, 10 multiply-subtract, 11 drain |
| a_i | input | 32 | First signed operand |
| b_i | input | 32 | Second signed operand |
| lo_we_i | input | 1 | Write enable for the low half |
| hi_we_i | input | 1 | Write enable for the high half |
| wdata_i | input | 32 | Write data for either half |
| drain_o | output | 32 | Window captured by the last drain |
| acc_lo_o | output | 32 | Sum bits 31:0 |
| acc_hi_o | output | 32 | Sum bits 63:32 |

## Verification
The bench builds the unit with its defaults: 32-bit operands, a 64-bit sum and a drain shift of 28. At these sizes the operand extremes are exercised: the most positive value squared, the most negative value squared, and products of mixed sign. Two of those squares in a row carry the sum across bit 63. A multiply-subtract then wraps it back. Drains are taken from positive sums and from negative sums whose upper bits sit above the captured window, so both the sign fill and the bit-59 boundary are observed.

// File: rtl/mac_pkg.sv
package mac_pkg;

    typedef enum logic [1:0] {
        MAC_OP_IDLE  = 2'b00,
        MAC_OP_ADD   = 2'b01,
        MAC_OP_SUB   = 2'b10,
        MAC_OP_DRAIN = 2'b11
    } mac_op_e;

endpackage

// File: rtl/mac_mult.sv
module mac_mult #(
    parameter int OPW = 32
) (
    input  logic [OPW-1:0]   a_i,
    input  logic [OPW-1:0]   b_i,
    output logic [2*OPW-1:0] prod_o
);
    localparam int PW = 2 * OPW;

    logic signed [PW-1:0] a_ext;
    logic signed [PW-1:0] b_ext;

    // Sign-extend both operands first so the product is the full signed width.
    always_comb begin
        a_ext  = {{OPW{a_i[OPW-1]}}, a_i};
        b_ext  = {{OPW{b_i[OPW-1]}}, b_i};
        prod_o = a_ext * b_ext;
    end

endmodule

// File: rtl/mac_acc_next.sv
module mac_acc_next
    import mac_pkg::*;
#(
    parameter int OPW = 32
) (
    input  mac_op_e          op_i,
    input  logic [2*OPW-1:0] acc_i,
    input  logic [2*OPW-1:0] prod_i,
    input  logic             lo_we_i,
    input  logic             hi_we_i,
    input  logic [OPW-1:0]   wdata_i,
    output logic [2*OPW-1:0] acc_nxt_o
);
    localparam int ACCW = 2 * OPW;

    logic [OPW-1:0] lo_sel;
    logic [OPW-1:0] hi_sel;

    // Register writes apply only when no operation is issued.
    always_comb begin
        lo_sel = lo_we_i ? wdata_i : acc_i[OPW-1:0];
        hi_sel = hi_we_i ? wdata_i : acc_i[ACCW-1:OPW];
    end

    always_comb begin
        unique case (op_i)
            MAC_OP_IDLE:  acc_nxt_o = {hi_sel, lo_sel};
            MAC_OP_ADD:   acc_nxt_o = acc_i + prod_i;
            MAC_OP_SUB:   acc_nxt_o = acc_i - prod_i;
            MAC_OP_DRAIN: acc_nxt_o = '0;
        endcase
    end

endmodule

// File: rtl/mac_drain_window.sv
module mac_drain_window #(
    parameter int OPW   = 32,
    parameter int SHIFT = 28
) (
    input  logic [2*OPW-1:0] acc_i,
    output logic [OPW-1:0]   win_o
);
    localparam int ACCW = 2 * OPW;

    generate
        if (SHIFT == 0) begin : g_noshift
            assign win_o = acc_i[OPW-1:0];
        end else begin : g_shift
            logic signed [ACCW-1:0] shifted;
            always_comb begin
                shifted = $signed(acc_i) >>> SHIFT;
            end
            assign win_o = shifted[OPW-1:0];
        end
    endgenerate

endmodule

// File: rtl/mac_acc_unit.sv
module mac_acc_unit
    import mac_pkg::*;
#(
    parameter int OPW   = 32,
    parameter int SHIFT = 28
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [1:0]     op_i,
    input  logic [OPW-1:0] a_i,
    input  logic [OPW-1:0] b_i,
    input  logic           lo_we_i,
    input  logic           hi_we_i,
    input  logic [OPW-1:0] wdata_i,
    output logic [OPW-1:0] drain_o,
    output logic [OPW-1:0] acc_lo_o,
    output logic [OPW-1:0] acc_hi_o
);
    localparam int ACCW = 2 * OPW;

    mac_op_e         op;
    logic [ACCW-1:0] acc_q;
    logic [ACCW-1:0] acc_nxt;
    logic [ACCW-1:0] prod;
    logic [OPW-1:0]  win;
    logic [OPW-1:0]  drain_q;

    assign op = mac_op_e'(op_i);

    mac_mult #(.OPW(OPW)) u_mult (
        .a_i    (a_i),
        .b_i    (b_i),
        .prod_o (prod)
    );

    mac_acc_next #(.OPW(OPW)) u_next (
        .op_i      (op),
        .acc_i     (acc_q),
        .prod_i    (prod),
        .lo_we_i   (lo_we_i),
        .hi_we_i   (hi_we_i),
        .wdata_i   (wdata_i),
        .acc_nxt_o (acc_nxt)
    );

    mac_drain_window #(.OPW(OPW), .SHIFT(SHIFT)) u_win (
        .acc_i (acc_q),
        .win_o (win)
    );

    // Sum register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q <= '0;
        end else begin
            acc_q <= acc_nxt;
        end
    end

    // Drain capture register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            drain_q <= '0;
        end else if (op == MAC_OP_DRAIN) begin
            drain_q <= win;
        end
    end

    assign acc_lo_o = acc_q[OPW-1:0];
    assign acc_hi_o = acc_q[ACCW-1:OPW];
    assign drain_o  = drain_q;

    // R2: multiply-add result relative to previous sum and operands
    a_r2_add: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 2'b01) |=>
            ({acc_hi_o, acc_lo_o} == ($past({acc_hi_o, acc_lo_o})
                + ({{OPW{$past(a_i[OPW-1])}}, $past(a_i)}
                 * {{OPW{$past(b_i[OPW-1])}}, $past(b_i)}))));

    // R3: multiply-subtract result
    a_r3_sub: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 2'b10) |=>
            ({acc_hi_o, acc_lo_o} == ($past({acc_hi_o, acc_lo_o})
                - ({{OPW{$past(a_i[OPW-1])}}, $past(a_i)}
                 * {{OPW{$past(b_i[OPW-1])}}, $past(b_i)}))));

    // R4: drain clears both halves
    a_r4_drain_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 2'b11) |=> (acc_lo_o == '0 && acc_hi_o == '0));

    // R6: low-half write leaves high half untouched
    a_r6_lo_write: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 2'b00 && lo_we_i && !hi_we_i) |=>
            (acc_lo_o == $past(wdata_i) && acc_hi_o == $past(acc_hi_o)));

    // R7: a drain wins over a simultaneous write
    a_r7_op_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 2'b11 && (lo_we_i || hi_we_i)) |=>
            (acc_lo_o == '0 && acc_hi_o == '0));

    // R8: idle without writes holds the sum
    a_r8_hold_sum: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 2'b00 && !lo_we_i && !hi_we_i) |=>
            ($stable(acc_lo_o) && $stable(acc_hi_o)));

    // R8: drain output moves only on a drain
    a_r8_hold_drain: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i != 2'b11) |=> $stable(drain_o));

endmodule

// File: tb/mac_acc_unit_tb.sv
module mac_acc_unit_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int NVEC       = 17;

    typedef struct packed {
        logic [1:0]  op;
        logic [31:0] a;
        logic [31:0] b;
        logic        lo_we;
        logic        hi_we;
        logic [31:0] wdata;
        logic [31:0] exp_lo;
        logic [31:0] exp_hi;
        logic [31:0] exp_dr;
        logic [15:0] tag;
    } vec_t;

    // Each row is one clock; rows run back to back (R5).
    localparam vec_t VEC [NVEC] = '{
        // R2: 3*5
        '{2'b01, 32'd3, 32'd5, 1'b0, 1'b0, 32'h0, 32'h0000000F, 32'h0, 32'h0, "R2"},
        // R2: -2*7 with mixed sign
        '{2'b01, 32'hFFFFFFFE, 32'd7, 1'b0, 1'b0, 32'h0, 32'h00000001, 32'h0, 32'h0, "R2"},
        // R3: 1 - 16 goes negative
        '{2'b10, 32'd4, 32'd4, 1'b0, 1'b0, 32'h0, 32'hFFFFFFF1, 32'hFFFFFFFF, 32'h0, "R3"},
        // R2: most positive squared
        '{2'b01, 32'h7FFFFFFF, 32'h7FFFFFFF, 1'b0, 1'b0, 32'h0, 32'hFFFFFFF2, 32'h3FFFFFFE, 32'h0, "R2"},
        // R4: drain straight after accumulate (R5)
        '{2'b11, 32'h0, 32'h0, 1'b0, 1'b0, 32'h0, 32'h0, 32'h0, 32'hFFFFFFEF, "R4"},
        // R2: most negative squared
        '{2'b01, 32'h80000000, 32'h80000000, 1'b0, 1'b0, 32'h0, 32'h0, 32'h40000000, 32'hFFFFFFEF, "R2"},
        // R9: crosses bit 63
        '{2'b01, 32'h80000000, 32'h80000000, 1'b0, 1'b0, 32'h0, 32'h0, 32'h80000000, 32'hFFFFFFEF, "R9"},
        // R9: subtract wraps back below the sign bit
        '{2'b10, 32'd1, 32'h10000000, 1'b0, 1'b0, 32'h0, 32'hF0000000, 32'h7FFFFFFF, 32'hFFFFFFEF, "R9"},
        // R4: window of a large positive sum
        '{2'b11, 32'h0, 32'h0, 1'b0, 1'b0, 32'h0, 32'h0, 32'h0, 32'hFFFFFFFF, "R4"},
        // R6: write low half only
        '{2'b00, 32'h0, 32'h0, 1'b1, 1'b0, 32'h12345678, 32'h12345678, 32'h0, 32'hFFFFFFFF, "R6"},
        // R6: write high half only
        '{2'b00, 32'h0, 32'h0, 1'b0, 1'b1, 32'hF0000000, 32'h12345678, 32'hF0000000, 32'hFFFFFFFF, "R6"},
        // R7: accumulate wins over low write
        '{2'b01, 32'd1, 32'd1, 1'b1, 1'b0, 32'hDEADBEEF, 32'h12345679, 32'hF0000000, 32'hFFFFFFFF, "R7"},
        // R4: negative sum, upper bits above the window
        '{2'b11, 32'h0, 32'h0, 1'b0, 1'b0, 32'h0, 32'h0, 32'h0, 32'h00000001, "R4"},
        // R6: both halves at once
        '{2'b00, 32'h0, 32'h0, 1'b1, 1'b1, 32'h00000ABC, 32'h00000ABC, 32'h00000ABC, 32'h00000001, "R6"},
        // R7: drain wins over high write
        '{2'b11, 32'h0, 32'h0, 1'b0, 1'b1, 32'h00000055, 32'h0, 32'h0, 32'h0000ABC0, "R7"},
        // R8: idle holds everything
        '{2'b00, 32'h0, 32'h0, 1'b0, 1'b0, 32'h0, 32'h0, 32'h0, 32'h0000ABC0, "R8"},
        // R3: subtract a negative product
        '{2'b10, 32'hFFFFFFFF, 32'd3, 1'b0, 1'b0, 32'h0, 32'h00000003, 32'h0, 32'h0000ABC0, "R3"}
    };

    logic        clk = 1'b0;
    logic        rst_n;
    logic [1:0]  op_i;
    logic [31:0] a_i;
    logic [31:0] b_i;
    logic        lo_we_i;
    logic        hi_we_i;
    logic [31:0] wdata_i;
    logic [31:0] drain_o;
    logic [31:0] acc_lo_o;
    logic [31:0] acc_hi_o;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    mac_acc_unit #(.OPW(32), .SHIFT(28)) dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .op_i     (op_i),
        .a_i      (a_i),
        .b_i      (b_i),
        .lo_we_i  (lo_we_i),
        .hi_we_i  (hi_we_i),
        .wdata_i  (wdata_i),
        .drain_o  (drain_o),
        .acc_lo_o (acc_lo_o),
        .acc_hi_o (acc_hi_o)
    );

    task automatic chk(input logic [15:0] tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic chk_all(input logic [15:0] tag, input logic [31:0] lo,
                           input logic [31:0] hi, input logic [31:0] dr);
        chk(tag, "acc_lo", acc_lo_o, lo);
        chk(tag, "acc_hi", acc_hi_o, hi);
        chk(tag, "drain",  drain_o,  dr);
    endtask

    task automatic drive(input logic [1:0] op, input logic [31:0] a,
                         input logic [31:0] b, input logic lw, input logic hw,
                         input logic [31:0] wd);
        op_i = op; a_i = a; b_i = b; lo_we_i = lw; hi_we_i = hw; wdata_i = wd;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 5000 && !done) begin
            done = 1'b1;
            fails++;
            $display("FAIL watchdog: actual %0d cycles expected below 5000", cycles);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0;
        drive(2'b00, 32'h0, 32'h0, 1'b0, 1'b0, 32'h0);
        repeat (3) @(negedge clk);
        chk_all("R1", 32'h0, 32'h0, 32'h0);       // R1 during reset
        rst_n = 1'b1;
        @(negedge clk);
        chk_all("R1", 32'h0, 32'h0, 32'h0);       // R1 first cycle out

        for (int i = 0; i < NVEC; i++) begin
            drive(VEC[i].op, VEC[i].a, VEC[i].b, VEC[i].lo_we, VEC[i].hi_we, VEC[i].wdata);
            @(negedge clk);
            chk_all(VEC[i].tag, VEC[i].exp_lo, VEC[i].exp_hi, VEC[i].exp_dr);
        end

        // R8: several idle cycles hold the sum of 3
        drive(2'b00, 32'h11, 32'h22, 1'b0, 1'b0, 32'hFFFF);
        repeat (4) @(negedge clk);
        chk_all("R8", 32'h3, 32'h0, 32'h0000ABC0);

        // R5: add then drain on the next cycle sees the added value
        drive(2'b01, 32'h10000000, 32'd5, 1'b0, 1'b0, 32'h0);
        @(negedge clk);
        drive(2'b11, 32'h0, 32'h0, 1'b0, 1'b0, 32'h0);
        @(negedge clk);
        chk_all("R5", 32'h0, 32'h0, 32'h00000005);

        // R1: reset in the middle of a run zeroes everything
        drive(2'b00, 32'h0, 32'h0, 1'b1, 1'b1, 32'hCAFE0001);
        @(negedge clk);
        drive(2'b00, 32'h0, 32'h0, 1'b0, 1'b0, 32'h0);
        rst_n = 1'b0;
        #1;
        chk_all("R1", 32'h0, 32'h0, 32'h0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk_all("R1", 32'h0, 32'h0, 32'h0);

        // R3: subtracting from zero gives the negated product
        drive(2'b10, 32'h00010000, 32'h00010000, 1'b0, 1'b0, 32'h0);
        @(negedge clk);
        drive(2'b00, 32'h0, 32'h0, 1'b0, 1'b0, 32'h0);
        chk_all("R3", 32'h0, 32'hFFFFFFFF, 32'h0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule